// File: doc/BRIEF.md
# Worst-Slowdown Bandwidth Rebalancer

This block spreads a fixed pool of memory bandwidth over a set of cores so that the most slowed-down core is helped first. Each core's bandwidth share is an allocation register. A target slowdown bound is held alongside them. The block reads one slowdown estimate per core on every interval strobe and compares each estimate with the bound. Cores at or under the bound act as donors. Cores above it act as receivers. Each donor gives up a small fixed step, but never drops below a floor. The collected amount is shared out over the receivers.

The block also retunes the bound from recent history. After several intervals in a row in which every core met the bound, the bound is pulled down toward the worst observed slowdown plus a small margin. After several intervals in a row in which a strict majority of cores missed it, the bound is relaxed to the worst observed slowdown. The bound is always visible on an output so that software can read it, and the allocation outputs feed a memory scheduler that lies outside this block.

Top module: `bw_rebalancer`

## Requirements
- R1: While reset is asserted and until the first strobe, every allocation equals INIT_ALLOC and the bound equals INIT_BOUND.
- R2: On a strobe, core i counts as meeting the bound when its slowdown is less than or equal to the current bound (unsigned compare). It counts as missing when its slowdown is greater than the bound.
- R3: When bandwidth moves, each meeting core gives min(STEP, allocation − MIN_ALLOC) and never gains bandwidth.
- R4: The collected amount P is split over the k missing cores. Each receives floor(P/k), and the lowest-indexed missing core also receives P mod k.
- R5: The sum of all allocations always equals NCORE × INIT_ALLOC.
- R6: When no core misses the bound, or no core meets it, every allocation stays the same for that interval.
- R7: When every core has met the bound on HIST_N strobes in a row, the bound becomes the largest slowdown of that strobe plus MARGIN, saturating at the all-ones value. The run count then restarts. Any strobe with a miss restarts the run.
- R8: When more than NCORE/2 cores have missed the bound on HIST_N strobes in a row, the bound becomes the largest slowdown of that strobe. The run count then restarts. Any strobe without such a majority restarts the run.
- R9: Allocations and bound change only in the cycle after a strobe. Slowdown inputs are ignored in cycles without a strobe.
- R10: No allocation ever falls below MIN_ALLOC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Interval-end strobe, one cycle wide |
| slowdown_i | input | NCORE*SD_W | Per-core slowdown estimates; core i occupies bits [i*SD_W +: SD_W] |
| alloc_o | output | NCORE*AW | Per-core bandwidth allocation; core i at [i*AW +: AW], AW = clog2(NCORE*INIT_ALLOC+1) |
| bound_o | output | SD_W | Current target slowdown bound |

## Verification
Every result is registered once. The allocations and the bound produced from a strobe sampled at rising edge t appear right after edge t. They hold through every later edge that has no strobe. The bench's reference model takes the same sampled inputs at each rising edge and updates its own state at that edge. One nanosecond later, with the design's outputs settled, the bench compares every allocation and the bound with the model. So the cycle in which each value is due is checked, and so is every idle cycle in which nothing may move. Inputs change only on falling edges.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    typedef enum logic [1:0] {
        BND_HOLD    = 2'd0,
        BND_TIGHTEN = 2'd1,
        BND_RELAX   = 2'd2
    } bnd_act_e;

endpackage

// File: rtl/bwr_classify.sv
module bwr_classify #(
    parameter int NCORE = 4,
    parameter int SD_W  = 8,
    parameter int CNT_W = 3
) (
    input  logic [NCORE-1:0][SD_W-1:0] sd_i,
    input  logic [SD_W-1:0]            bound_i,
    output logic [NCORE-1:0]           meet_o,
    output logic [CNT_W-1:0]           nmiss_o,
    output logic [SD_W-1:0]            max_o
);

    always_comb begin
        nmiss_o = '0;
        max_o   = '0;
        for (int i = 0; i < NCORE; i++) begin
            meet_o[i] = (sd_i[i] <= bound_i);
            if (!meet_o[i]) begin
                nmiss_o = nmiss_o + CNT_W'(1);
            end
            if (sd_i[i] > max_o) begin
                max_o = sd_i[i];
            end
        end
    end

endmodule

// File: rtl/bwr_donate.sv
module bwr_donate #(
    parameter int NCORE     = 4,
    parameter int AW        = 9,
    parameter int STEP      = 8,
    parameter int MIN_ALLOC = 16,
    parameter int CNT_W     = 3
) (
    input  logic [NCORE-1:0][AW-1:0] alloc_i,
    input  logic [NCORE-1:0]         meet_i,
    input  logic [CNT_W-1:0]         nmiss_i,
    output logic [NCORE-1:0][AW-1:0] alloc_o,
    output logic                     move_o
);

    localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1;

    logic [NCORE-1:0][AW-1:0] give;
    logic [AW-1:0]            pool;
    logic [AW-1:0]            divisor;
    logic [AW-1:0]            share;
    logic [AW-1:0]            rem;
    logic [IW-1:0]            first;
    logic                     found;

    // Donor side: fixed step, clipped so the floor is kept.
    always_comb begin
        pool = '0;
        for (int i = 0; i < NCORE; i++) begin
            give[i] = '0;
            if (meet_i[i] && (alloc_i[i] > AW'(MIN_ALLOC))) begin
                give[i] = alloc_i[i] - AW'(MIN_ALLOC);
                if (give[i] > AW'(STEP)) begin
                    give[i] = AW'(STEP);
                end
            end
            pool = pool + give[i];
        end
    end

    // Receiver side: even split, remainder to the lowest missing index.
    always_comb begin
        move_o  = (nmiss_i != '0) && (nmiss_i != CNT_W'(NCORE));
        divisor = (nmiss_i == '0) ? AW'(1) : AW'(nmiss_i);
        share   = pool / divisor;
        rem     = pool % divisor;
        found   = 1'b0;
        first   = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (!meet_i[i] && !found) begin
                first = IW'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < NCORE; i++) begin
            if (!move_o) begin
                alloc_o[i] = alloc_i[i];
            end else if (meet_i[i]) begin
                alloc_o[i] = alloc_i[i] - give[i];
            end else begin
                alloc_o[i] = alloc_i[i] + share + ((IW'(i) == first) ? rem : '0);
            end
        end
    end

endmodule

// File: rtl/bwr_bound.sv
module bwr_bound
    import bwr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int SD_W   = 8,
    parameter int CNT_W  = 3,
    parameter int HIST_N = 3,
    parameter int RUN_W  = 2,
    parameter int MARGIN = 4
) (
    input  logic [CNT_W-1:0] nmiss_i,
    input  logic [SD_W-1:0]  max_i,
    input  logic [SD_W-1:0]  bound_i,
    input  logic [RUN_W-1:0] met_run_i,
    input  logic [RUN_W-1:0] miss_run_i,
    output logic [SD_W-1:0]  bound_o,
    output logic [RUN_W-1:0] met_run_o,
    output logic [RUN_W-1:0] miss_run_o,
    output bnd_act_e         act_o
);

    logic            all_met;
    logic            majority_miss;
    logic [SD_W:0]   tight_sum;

    always_comb begin
        all_met       = (nmiss_i == '0);
        majority_miss = (nmiss_i > CNT_W'(NCORE / 2));
        tight_sum     = {1'b0, max_i} + (SD_W + 1)'(MARGIN);

        met_run_o  = all_met       ? met_run_i  + RUN_W'(1) : '0;
        miss_run_o = majority_miss ? miss_run_i + RUN_W'(1) : '0;
        act_o      = BND_HOLD;
        bound_o    = bound_i;

        if (met_run_o == RUN_W'(HIST_N)) begin
            act_o     = BND_TIGHTEN;
            met_run_o = '0;
            bound_o   = tight_sum[SD_W] ? {SD_W{1'b1}} : tight_sum[SD_W-1:0];
        end else if (miss_run_o == RUN_W'(HIST_N)) begin
            act_o      = BND_RELAX;
            miss_run_o = '0;
            bound_o    = max_i;
        end
    end

endmodule

// File: rtl/bw_rebalancer.sv
module bw_rebalancer
    import bwr_pkg::*;
#(
    parameter int NCORE      = 4,
    parameter int SD_W       = 8,
    parameter int INIT_ALLOC = 64,
    parameter int MIN_ALLOC  = 16,
    parameter int STEP       = 8,
    parameter int HIST_N     = 3,
    parameter int MARGIN     = 4,
    parameter int INIT_BOUND = 48,
    localparam int AW        = $clog2(NCORE * INIT_ALLOC + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic [NCORE*SD_W-1:0] slowdown_i,
    output logic [NCORE*AW-1:0]   alloc_o,
    output logic [SD_W-1:0]       bound_o
);

    localparam int CNT_W = $clog2(NCORE + 1);
    localparam int RUN_W = $clog2(HIST_N + 1);
    localparam int TOTAL = NCORE * INIT_ALLOC;

    typedef struct packed {
        logic [NCORE-1:0][AW-1:0] alloc;
        logic [SD_W-1:0]          bound;
        logic [RUN_W-1:0]         met_run;
        logic [RUN_W-1:0]         miss_run;
    } state_t;

    state_t st_d, st_q;

    logic [NCORE-1:0][SD_W-1:0] sd;
    logic [NCORE-1:0]           meet;
    logic [CNT_W-1:0]           nmiss;
    logic [SD_W-1:0]            sd_max;
    logic [NCORE-1:0][AW-1:0]   alloc_nx;
    logic                       move;
    logic [SD_W-1:0]            bound_nx;
    logic [RUN_W-1:0]           met_run_nx;
    logic [RUN_W-1:0]           miss_run_nx;
    bnd_act_e                   act;

    assign sd = slowdown_i;

    bwr_classify #(
        .NCORE (NCORE),
        .SD_W  (SD_W),
        .CNT_W (CNT_W)
    ) classify_i (
        .sd_i    (sd),
        .bound_i (st_q.bound),
        .meet_o  (meet),
        .nmiss_o (nmiss),
        .max_o   (sd_max)
    );

    bwr_donate #(
        .NCORE     (NCORE),
        .AW        (AW),
        .STEP      (STEP),
        .MIN_ALLOC (MIN_ALLOC),
        .CNT_W     (CNT_W)
    ) donate_i (
        .alloc_i (st_q.alloc),
        .meet_i  (meet),
        .nmiss_i (nmiss),
        .alloc_o (alloc_nx),
        .move_o  (move)
    );

    bwr_bound #(
        .NCORE  (NCORE),
        .SD_W   (SD_W),
        .CNT_W  (CNT_W),
        .HIST_N (HIST_N),
        .RUN_W  (RUN_W),
        .MARGIN (MARGIN)
    ) bound_i (
        .nmiss_i    (nmiss),
        .max_i      (sd_max),
        .bound_i    (st_q.bound),
        .met_run_i  (st_q.met_run),
        .miss_run_i (st_q.miss_run),
        .bound_o    (bound_nx),
        .met_run_o  (met_run_nx),
        .miss_run_o (miss_run_nx),
        .act_o      (act)
    );

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.alloc    = alloc_nx;
            st_d.bound    = bound_nx;
            st_d.met_run  = met_run_nx;
            st_d.miss_run = miss_run_nx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NCORE; i++) begin
                st_q.alloc[i] <= AW'(INIT_ALLOC);
            end
            st_q.bound    <= SD_W'(INIT_BOUND);
            st_q.met_run  <= '0;
            st_q.miss_run <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_o = st_q.alloc;
    assign bound_o = st_q.bound;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic [AW+CNT_W-1:0] alloc_sum;
    always_comb begin
        alloc_sum = '0;
        for (int i = 0; i < NCORE; i++) begin
            alloc_sum = alloc_sum + (AW + CNT_W)'(st_q.alloc[i]);
        end
    end

    // R5
    sum_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_sum == (AW + CNT_W)'(TOTAL));

    // R9
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> ($stable(st_q.alloc) && $stable(st_q.bound)));

    // R6
    no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && ((nmiss == '0) || (nmiss == CNT_W'(NCORE)))) |=> $stable(st_q.alloc));

    // R8
    relax_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && (act == BND_RELAX)) |=> (st_q.bound == $past(sd_max)));

    for (genvar g = 0; g < NCORE; g++) begin : g_core_chk
        // R10
        floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            st_q.alloc[g] >= AW'(MIN_ALLOC));

        // R3
        donor_no_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_i && meet[g]) |=> (st_q.alloc[g] <= $past(st_q.alloc[g])));
    end

endmodule

// File: tb/bw_rebalancer_tb_top.sv
`timescale 1ns/1ps
module bw_rebalancer_tb_top;

    localparam int NCORE      = 4;
    localparam int SD_W       = 8;
    localparam int INIT_ALLOC = 64;
    localparam int MIN_ALLOC  = 16;
    localparam int STEP       = 8;
    localparam int HIST_N     = 3;
    localparam int MARGIN     = 4;
    localparam int INIT_BOUND = 48;
    localparam int AW         = $clog2(NCORE * INIT_ALLOC + 1);
    localparam int SDMAX      = (1 << SD_W) - 1;

    logic                  clk;
    logic                  rst_n;
    logic                  tick;
    logic [NCORE*SD_W-1:0] sd_bus;
    logic [NCORE*AW-1:0]   alloc_bus;
    logic [SD_W-1:0]       bound;

    int errors = 0;
    int checks = 0;

    int m_alloc [NCORE];
    int m_bound;
    int m_met_run;
    int m_miss_run;
    int sd_val [NCORE];

    bw_rebalancer #(
        .NCORE      (NCORE),
        .SD_W       (SD_W),
        .INIT_ALLOC (INIT_ALLOC),
        .MIN_ALLOC  (MIN_ALLOC),
        .STEP       (STEP),
        .HIST_N     (HIST_N),
        .MARGIN     (MARGIN),
        .INIT_BOUND (INIT_BOUND)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .slowdown_i (sd_bus),
        .alloc_o    (alloc_bus),
        .bound_o    (bound)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCORE; i++) begin
            sd_bus[i*SD_W +: SD_W] = SD_W'(sd_val[i]);
        end
    end

    // Behavioural reference model, updated on every rising edge.
    task automatic model_reset();
        for (int i = 0; i < NCORE; i++) m_alloc[i] = INIT_ALLOC;
        m_bound    = INIT_BOUND;
        m_met_run  = 0;
        m_miss_run = 0;
    endtask

    task automatic model_step();
        int nmiss, mx, pool, share, rem;
        int take [NCORE];
        bit first_done;
        nmiss = 0; mx = 0; pool = 0;
        for (int i = 0; i < NCORE; i++) begin
            if (sd_val[i] > m_bound) nmiss++;
            if (sd_val[i] > mx) mx = sd_val[i];
        end
        if (nmiss > 0 && nmiss < NCORE) begin
            for (int i = 0; i < NCORE; i++) begin
                take[i] = 0;
                if (sd_val[i] <= m_bound) begin
                    take[i] = m_alloc[i] - MIN_ALLOC;
                    if (take[i] > STEP) take[i] = STEP;
                    if (take[i] < 0) take[i] = 0;
                    pool += take[i];
                end
            end
            share = pool / nmiss;
            rem   = pool % nmiss;
            first_done = 0;
            for (int i = 0; i < NCORE; i++) begin
                if (sd_val[i] <= m_bound) begin
                    m_alloc[i] -= take[i];
                end else begin
                    m_alloc[i] += share;
                    if (!first_done) begin
                        m_alloc[i] += rem;
                        first_done = 1;
                    end
                end
            end
        end
        m_met_run  = (nmiss == 0) ? m_met_run + 1 : 0;
        m_miss_run = (2 * nmiss > NCORE) ? m_miss_run + 1 : 0;
        if (m_met_run == HIST_N) begin
            m_met_run = 0;
            m_bound   = (mx + MARGIN > SDMAX) ? SDMAX : mx + MARGIN;
        end else if (m_miss_run == HIST_N) begin
            m_miss_run = 0;
            m_bound    = mx;
        end
    endtask

    bit seen_tick = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
            seen_tick = 0;
        end else if (tick) begin
            model_step();
            seen_tick = 1;
        end
    end

    // Compare 1 ns after every rising edge.
    always @(posedge clk) begin
        #1;
        compare_all();
    end

    task automatic compare_all();
        int sum;
        int got;
        sum = 0;
        for (int i = 0; i < NCORE; i++) begin
            got = int'(alloc_bus[i*AW +: AW]);
            sum += got;
            checks++;
            if (got != m_alloc[i]) begin
                errors++;
                if (!seen_tick)
                    $display("FAIL R1 alloc[%0d]: actual=%0d expected=%0d", i, got, m_alloc[i]);
                else
                    $display("FAIL R2 R3 R4 R6 R9 alloc[%0d]: actual=%0d expected=%0d",
                             i, got, m_alloc[i]);
            end
            checks++;
            if (got < MIN_ALLOC) begin
                errors++;
                $display("FAIL R10 alloc[%0d] below floor: actual=%0d expected>=%0d",
                         i, got, MIN_ALLOC);
            end
        end
        checks++;
        if (sum != NCORE * INIT_ALLOC) begin
            errors++;
            $display("FAIL R5 allocation sum: actual=%0d expected=%0d", sum, NCORE * INIT_ALLOC);
        end
        checks++;
        if (int'(bound) != m_bound) begin
            errors++;
            if (!seen_tick)
                $display("FAIL R1 bound: actual=%0d expected=%0d", bound, m_bound);
            else
                $display("FAIL R7 R8 R9 bound: actual=%0d expected=%0d", bound, m_bound);
        end
    endtask

    task automatic set_sd(input int a, input int b, input int c, input int d);
        sd_val[0] = a; sd_val[1] = b; sd_val[2] = c; sd_val[3] = d;
    endtask

    // One interval: strobe for one cycle, then idle cycles with noise on the inputs (R9).
    task automatic interval(input int a, input int b, input int c, input int d, input int idle);
        @(negedge clk);
        set_sd(a, b, c, d);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int k = 0; k < idle; k++) begin
            for (int i = 0; i < NCORE; i++) sd_val[i] = $urandom_range(0, SDMAX);
            @(negedge clk);
        end
    endtask

    task automatic direct_check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick  = 1'b0;
        rst_n = 1'b0;
        set_sd(200, 200, 200, 200);
        repeat (4) @(negedge clk);
        // R1: reset values seen at the ports
        direct_check("R1 bound after reset", int'(bound), INIT_BOUND);
        direct_check("R1 alloc0 after reset", int'(alloc_bus[0 +: AW]), INIT_ALLOC);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: every core misses, nothing moves
        interval(200, 200, 200, 200, 2);
        direct_check("R6 alloc1 all missing", int'(alloc_bus[AW +: AW]), INIT_ALLOC);

        // R2 R3 R4: equality meets; core1 and core3 miss, pool 16 split 8/8
        interval(48, 49, 10, 60, 1);
        direct_check("R2 R3 alloc0 donor", int'(alloc_bus[0 +: AW]), INIT_ALLOC - STEP);
        direct_check("R4 alloc1 receiver", int'(alloc_bus[AW +: AW]), INIT_ALLOC + STEP);

        // R4: three receivers, pool 8 -> 2 each, remainder 2 to core1
        interval(5, 90, 90, 90, 1);
        direct_check("R4 alloc1 remainder", int'(alloc_bus[AW +: AW]), INIT_ALLOC + STEP + 4);

        // R7: all meet HIST_N times -> bound = 30 + MARGIN
        for (int r = 0; r < HIST_N; r++) interval(10, 20, 30, 5, 0);
        @(negedge clk);
        direct_check("R7 tightened bound", int'(bound), 30 + MARGIN);

        // R10: one core starves the others down to the floor
        for (int r = 0; r < 12; r++) interval(60, 5, 5, 5, 1);
        direct_check("R10 alloc2 at floor", int'(alloc_bus[2*AW +: AW]), MIN_ALLOC);

        // R8: three of four miss HIST_N times -> bound = largest slowdown
        for (int r = 0; r < HIST_N; r++) interval(120, 150, 130, 1, 1);
        direct_check("R8 relaxed bound", int'(bound), 150);

        // R7: saturation at all-ones
        for (int r = 0; r < HIST_N; r++) interval(150, 150, 150, 150, 0);
        @(negedge clk);
        direct_check("R7 bound tracks max plus margin", int'(bound), 154);
        set_sd(0, 0, 0, 0);
        for (int r = 0; r < 2 * HIST_N; r++) interval(SDMAX - 5, SDMAX - 200, 3, 0, 0);
        for (int r = 0; r < 2 * HIST_N; r++) interval(SDMAX, SDMAX, SDMAX, 0, 0);
        for (int r = 0; r < HIST_N; r++) interval(SDMAX - 1, 2, 2, 2, 0);
        @(negedge clk);

        // Mixed patterns, compared cycle by cycle against the model
        for (int r = 0; r < 400; r++) begin
            interval($urandom_range(0, 120), $urandom_range(0, 120),
                     $urandom_range(0, 120), $urandom_range(0, 120),
                     $urandom_range(0, 3));
        end

        // R9: long idle with changing inputs
        repeat (20) begin
            for (int i = 0; i < NCORE; i++) sd_val[i] = $urandom_range(0, SDMAX);
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule